// File: doc/BRIEF.md
# Clock Output Gating and PLL Mode Controller

This block is the control core of a two-output reference clock buffer. It decides, separately for each output, whether the driver is allowed to toggle or is parked with both legs low, and it settles which PLL bandwidth mode and which input frequency range are in effect. It works entirely in the reference-clock domain. Its inputs are the active-low per-output enable pins, the power-good/power-down pin, a PLL lock flag, the already-decoded value of the three-level mode strap, and control bits held by the serial register block. Its outputs are one run flag per output, the PLL mode code, the latched strap value for readback, a PLL power-down request and the frequency range code.

The power-good pin works in two phases. Its first high level samples the mode strap, keeps that value, and brings the device up. After that, a low level puts the device into power-down and a later high level wakes it again. The strap is never sampled a second time. Register fields may replace the strap-selected mode and the default frequency range, but only while their enable bits are set. Enable pins and the power-good pin pass through synchronizers, so a change on a pin reaches the outputs after a fixed number of reference cycles.

Top module: `clkbuf_ctrl`

## Requirements
- R1: Output i runs (`out_run[i]`=1) only when `reg_oe_en[i]`=1, `oe_n_pin[i]`=0, the device is powered up, and either `pll_locked`=1 or the effective mode is bypass. In every other case it is parked (`out_run[i]`=0). A change on `reg_oe_en` or `pll_locked` reaches `out_run` one rising edge later.
- R2: A change on `oe_n_pin[i]` reaches `out_run[i]` on exactly the third rising edge of `clk_ref` after the change, and never earlier.
- R3: From reset until the first high on `pwrgd_pin`, and at any time the synchronized `pwrgd_pin` is low after that, the device is powered down: `pll_pd`=1 and `out_run`=0.
- R4: The first high on `pwrgd_pin` takes effect on the third rising edge and captures `mode_pin` into `mode_rdbk` on that edge. Later changes on `mode_pin`, and power-down/power-up cycles, leave `mode_rdbk` unchanged. `mode_rdbk` is 00 after reset.
- R5: Mode codes are 00 low bandwidth, 01 bypass and 11 high bandwidth. The reserved code 10 is driven on `pll_mode` as 00.
- R6: When `reg_mode_sw_en`=1, `pll_mode` follows `reg_mode_sw`. When it is 0, `pll_mode` follows the captured strap. Either way the new value appears one rising edge later.
- R7: While powered up in bypass mode, `pll_pd`=1, and enabled outputs run even when `pll_locked`=0. While powered up in any other mode, `pll_pd`=0.
- R8: When `reg_freq_sw_en`=0, `freq_sel` is 00 (100 MHz). When it is 1, the codes 00 (100 MHz), 01 (50 MHz) and 10 (125 MHz) pass to `freq_sel` one edge later, and the reserved code 11 keeps the previous `freq_sel`.
- R9: During reset `out_run`=0, `pll_mode`=00, `mode_rdbk`=00, `freq_sel`=00 and `pll_pd`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that everything is registered on |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n_pin | input | N_OUT | Active-low per-output enable pins (asynchronous) |
| pwrgd_pin | input | 1 | Power-good / power-down pin (asynchronous) |
| pll_locked | input | 1 | PLL lock indication |
| mode_pin | input | 2 | Decoded three-level mode strap |
| reg_oe_en | input | N_OUT | Register enable bit per output; 0 parks the output |
| reg_mode_sw_en | input | 1 | Lets `reg_mode_sw` select the mode |
| reg_mode_sw | input | 2 | Register-selected mode code |
| reg_freq_sw_en | input | 1 | Lets `reg_freq_sw` select the frequency range |
| reg_freq_sw | input | 2 | Register-selected frequency code |
| out_run | output | N_OUT | Per-output run (1) / park low-low (0) |
| pll_mode | output | 2 | Effective PLL mode code |
| mode_rdbk | output | 2 | Strap value captured at first power-good |
| pll_pd | output | 1 | PLL power-down request |
| freq_sel | output | 2 | Effective frequency range code |

## Verification
Directed sequences cover the power-up capture of the strap, the three-edge pin latency (checked on the edge before the change and on the edge of the change), and power-down and wake-up with a changed strap. Together these separate a correct latch from one that samples again at every wake-up. Random patterns then vary all register bits, the lock flag and the enable pins at once, and hold each pattern long enough to settle. Because the four gating conditions change independently, a dropped condition or an inverted pin shows up as a wrong run flag. Mixing bypass with lock low shows whether the lock bypass is tied to the effective mode rather than to the strap. The reserved frequency code always comes after a known legal code, so a wrong "keep previous" shows as a value mismatch.

// File: rtl/clkbuf_ctrl_pkg.sv
package clkbuf_ctrl_pkg;

    typedef enum logic [1:0] {
        MODE_LOBW = 2'b00,
        MODE_BYP  = 2'b01,
        MODE_RSV  = 2'b10,
        MODE_HIBW = 2'b11
    } pll_mode_e;

    typedef enum logic [1:0] {
        FREQ_100 = 2'b00,
        FREQ_50  = 2'b01,
        FREQ_125 = 2'b10,
        FREQ_RSV = 2'b11
    } freq_e;

    typedef enum logic [1:0] {
        PWR_NEVER = 2'b00,
        PWR_ON    = 2'b01,
        PWR_OFF   = 2'b10
    } pwr_state_e;

    function automatic logic [1:0] legal_mode(input logic [1:0] code);
        return (code == MODE_RSV) ? MODE_LOBW : code;
    endfunction

endpackage

// File: rtl/cbc_sync.sv
module cbc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= rst_val;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[LAST];
endmodule

// File: rtl/cbc_pwr_seq.sv
module cbc_pwr_seq
    import clkbuf_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwrgd_s,
    input  logic [1:0] mode_pin,
    output logic       active,
    output logic [1:0] mode_latched
);
    typedef struct packed {
        pwr_state_e st;
        logic [1:0] mode_lat;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d = q;
        unique case (q.st)
            PWR_NEVER: if (pwrgd_s) begin
                d.st       = PWR_ON;
                d.mode_lat = mode_pin;
            end
            PWR_ON:    if (!pwrgd_s) d.st = PWR_OFF;
            PWR_OFF:   if (pwrgd_s)  d.st = PWR_ON;
            default:   d.st = PWR_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= PWR_NEVER;
            q.mode_lat <= MODE_LOBW;
        end else begin
            q <= d;
        end
    end

    assign active       = (q.st == PWR_ON);
    assign mode_latched = q.mode_lat;

    // R4: once captured, the strap value never moves again
    assert_strap_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != PWR_NEVER) |=> $stable(q.mode_lat));

    // R4: the never-started state is left only by a sampled power-good
    assert_start_on_pwrgd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PWR_NEVER && !pwrgd_s) |=> (q.st == PWR_NEVER));
endmodule

// File: rtl/cbc_mode_sel.sv
module cbc_mode_sel
    import clkbuf_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [1:0] mode_latched,
    input  logic       sw_mode_en,
    input  logic [1:0] sw_mode,
    input  logic       sw_freq_en,
    input  logic [1:0] sw_freq,
    output logic [1:0] mode_eff,
    output logic [1:0] pll_mode,
    output logic       pll_pd,
    output logic [1:0] freq_sel
);
    typedef struct packed {
        logic [1:0] mode;
        logic       pd;
        logic [1:0] freq;
    } msel_t;

    msel_t d, q;

    always_comb begin
        mode_eff = legal_mode(sw_mode_en ? sw_mode : mode_latched);
        d        = q;
        d.mode   = mode_eff;
        d.pd     = !active || (mode_eff == MODE_BYP);
        if (!sw_freq_en) begin
            d.freq = FREQ_100;
        end else if (sw_freq != FREQ_RSV) begin
            d.freq = sw_freq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode <= MODE_LOBW;
            q.pd   <= 1'b1;
            q.freq <= FREQ_100;
        end else begin
            q <= d;
        end
    end

    assign pll_mode = q.mode;
    assign pll_pd   = q.pd;
    assign freq_sel = q.freq;

    // R5: the reserved mode code never reaches the PLL
    assert_no_rsv_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.mode != MODE_RSV);

    // R8: the reserved frequency code never reaches the output
    assert_no_rsv_freq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.freq != FREQ_RSV);

    // R8: a reserved request with the field enabled holds the setting
    assert_rsv_freq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_freq_en && sw_freq == FREQ_RSV) |=> $stable(q.freq));

    // R3: leaving the powered state always requests PLL power-down
    assert_pd_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> q.pd);
endmodule

// File: rtl/cbc_out_gate.sv
module cbc_out_gate
    import clkbuf_ctrl_pkg::*;
#(
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             pll_locked,
    input  logic [1:0]       mode_eff,
    input  logic [N_OUT-1:0] reg_oe_en,
    input  logic [N_OUT-1:0] oe_n_s,
    output logic [N_OUT-1:0] out_run
);
    logic clk_ok;

    assign clk_ok = active && (pll_locked || (mode_eff == MODE_BYP));

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        typedef struct packed {
            logic run;
        } gate_t;

        gate_t d, q;

        always_comb begin
            d     = q;
            d.run = clk_ok && reg_oe_en[i] && !oe_n_s[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q.run <= 1'b0;
            else        q     <= d;
        end

        assign out_run[i] = q.run;

        // R1: a register-disabled output is parked on the next edge
        assert_reg_park_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_oe_en[i] |=> !q.run);

        // R1: a deasserted pin (after sync) parks the output on the next edge
        assert_pin_park_R1: assert property (@(posedge clk) disable iff (!rst_n)
            oe_n_s[i] |=> !q.run);
    end
endmodule

// File: rtl/clkbuf_ctrl.sv
module clkbuf_ctrl
    import clkbuf_ctrl_pkg::*;
#(
    parameter int N_OUT       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] oe_n_pin,
    input  logic             pwrgd_pin,
    input  logic             pll_locked,
    input  logic [1:0]       mode_pin,
    input  logic [N_OUT-1:0] reg_oe_en,
    input  logic             reg_mode_sw_en,
    input  logic [1:0]       reg_mode_sw,
    input  logic             reg_freq_sw_en,
    input  logic [1:0]       reg_freq_sw,
    output logic [N_OUT-1:0] out_run,
    output logic [1:0]       pll_mode,
    output logic [1:0]       mode_rdbk,
    output logic             pll_pd,
    output logic [1:0]       freq_sel
);
    localparam int SYNC_W = N_OUT + 1;

    logic [SYNC_W-1:0] sync_in, sync_out, sync_rst;
    logic [N_OUT-1:0]  oe_n_s;
    logic              pwrgd_s;
    logic              active;
    logic [1:0]        mode_latched;
    logic [1:0]        mode_eff;

    assign sync_in  = {pwrgd_pin, oe_n_pin};
    assign sync_rst = {1'b0, {N_OUT{1'b1}}};
    assign oe_n_s   = sync_out[N_OUT-1:0];
    assign pwrgd_s  = sync_out[N_OUT];

    cbc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .rst_val  (sync_rst),
        .async_in (sync_in),
        .sync_out (sync_out)
    );

    cbc_pwr_seq u_pwr (
        .clk          (clk_ref),
        .rst_n        (rst_n),
        .pwrgd_s      (pwrgd_s),
        .mode_pin     (mode_pin),
        .active       (active),
        .mode_latched (mode_latched)
    );

    cbc_mode_sel u_mode (
        .clk          (clk_ref),
        .rst_n        (rst_n),
        .active       (active),
        .mode_latched (mode_latched),
        .sw_mode_en   (reg_mode_sw_en),
        .sw_mode      (reg_mode_sw),
        .sw_freq_en   (reg_freq_sw_en),
        .sw_freq      (reg_freq_sw),
        .mode_eff     (mode_eff),
        .pll_mode     (pll_mode),
        .pll_pd       (pll_pd),
        .freq_sel     (freq_sel)
    );

    cbc_out_gate #(.N_OUT(N_OUT)) u_gate (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .active     (active),
        .pll_locked (pll_locked),
        .mode_eff   (mode_eff),
        .reg_oe_en  (reg_oe_en),
        .oe_n_s     (oe_n_s),
        .out_run    (out_run)
    );

    assign mode_rdbk = mode_latched;

    // R7: a running output with the PLL powered down implies bypass mode
    assert_run_pd_bypass_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (out_run != '0 && pll_pd) |-> (pll_mode == MODE_BYP));

    // R3: outputs are parked one edge after the device leaves the powered state
    assert_park_when_off_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !active |=> (out_run == '0));

    // R7: in a PLL mode the PLL is never asked to power down while outputs run
    assert_pll_on_when_running_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (out_run != '0 && pll_mode != MODE_BYP) |-> !pll_pd);
endmodule

// File: tb/tb_clkbuf_ctrl.sv
module tb_clkbuf_ctrl;
    localparam int  N_OUT  = 2;
    localparam time CLK_T  = 10ns;
    localparam int  WDOG   = 100000;

    logic             clk_ref = 1'b0;
    logic             rst_n   = 1'b0;
    logic [N_OUT-1:0] oe_n_pin = '0;
    logic             pwrgd_pin = 1'b0;
    logic             pll_locked = 1'b0;
    logic [1:0]       mode_pin = 2'b00;
    logic [N_OUT-1:0] reg_oe_en = '1;
    logic             reg_mode_sw_en = 1'b0;
    logic [1:0]       reg_mode_sw = 2'b00;
    logic             reg_freq_sw_en = 1'b0;
    logic [1:0]       reg_freq_sw = 2'b00;
    logic [N_OUT-1:0] out_run;
    logic [1:0]       pll_mode, mode_rdbk, freq_sel;
    logic             pll_pd;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [1:0] strap_exp = 2'b00;
    logic [1:0] freq_exp  = 2'b00;
    logic       pwr_exp   = 1'b0;

    clkbuf_ctrl #(.N_OUT(N_OUT)) dut (
        .clk_ref, .rst_n, .oe_n_pin, .pwrgd_pin, .pll_locked, .mode_pin,
        .reg_oe_en, .reg_mode_sw_en, .reg_mode_sw, .reg_freq_sw_en,
        .reg_freq_sw, .out_run, .pll_mode, .mode_rdbk, .pll_pd, .freq_sel
    );

    always #(CLK_T/2) clk_ref = ~clk_ref;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    function automatic logic [1:0] f_mode();
        logic [1:0] m = reg_mode_sw_en ? reg_mode_sw : strap_exp;
        return (m == 2'b10) ? 2'b00 : m;
    endfunction

    function automatic logic [N_OUT-1:0] f_run();
        logic [N_OUT-1:0] r;
        for (int i = 0; i < N_OUT; i++)
            r[i] = pwr_exp && reg_oe_en[i] && !oe_n_pin[i] &&
                   (pll_locked || f_mode() == 2'b01);
        return r;
    endfunction

    function automatic logic f_pd();
        return !pwr_exp || f_mode() == 2'b01;
    endfunction

    task automatic upd_freq();
        if (!reg_freq_sw_en) freq_exp = 2'b00;
        else if (reg_freq_sw != 2'b11) freq_exp = reg_freq_sw;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R1 out_run"}, out_run, f_run());
        chk({tag, " R5/R6 pll_mode"}, pll_mode, f_mode());
        chk({tag, " R7/R3 pll_pd"}, pll_pd, f_pd());
        chk({tag, " R8 freq_sel"}, freq_sel, freq_exp);
        chk({tag, " R4 mode_rdbk"}, mode_rdbk, strap_exp);
    endtask

    initial begin : watchdog
        while (cyc < WDOG) begin
            @(posedge clk_ref);
            cyc++;
        end
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WDOG);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_0C1C));
        // R9: reset values
        ticks(3);
        chk("R9 out_run", out_run, 0);
        chk("R9 pll_mode", pll_mode, 0);
        chk("R9 mode_rdbk", mode_rdbk, 0);
        chk("R9 freq_sel", freq_sel, 0);
        chk("R9 pll_pd", pll_pd, 1);
        rst_n = 1'b1;
        pll_locked = 1'b1;
        mode_pin = 2'b11;
        ticks(6);
        // R3: not started yet
        chk("R3 pd before power-good", pll_pd, 1);
        chk("R3 parked before power-good", out_run, 0);

        // R4: capture on third edge
        pwrgd_pin = 1'b1;
        ticks(2);
        chk("R4 rdbk before third edge", mode_rdbk, 2'b00);
        ticks(1);
        chk("R4 strap captured", mode_rdbk, 2'b11);
        strap_exp = 2'b11; pwr_exp = 1'b1;
        mode_pin = 2'b01;
        ticks(2);
        check_all("powered hibw");

        // R2: pin latency exactly three edges
        oe_n_pin[0] = 1'b1;
        ticks(2);
        chk("R2 stop not before third edge", out_run[0], 1);
        ticks(1);
        chk("R2 stop on third edge", out_run[0], 0);
        oe_n_pin[0] = 1'b0;
        ticks(2);
        chk("R2 start not before third edge", out_run[0], 0);
        ticks(1);
        chk("R2 start on third edge", out_run[0], 1);

        // R1: lock loss parks outputs in a PLL mode
        pll_locked = 1'b0;
        ticks(1);
        chk("R1 parked without lock", out_run, 0);

        // R7: bypass runs without lock, PLL powered down
        reg_mode_sw_en = 1'b1; reg_mode_sw = 2'b01;
        ticks(1);
        chk("R7 bypass runs unlocked", out_run, 2'b11);
        chk("R7 bypass pll_pd", pll_pd, 1);
        chk("R6 sw mode applied", pll_mode, 2'b01);
        // R5: reserved mode code
        reg_mode_sw = 2'b10;
        ticks(1);
        chk("R5 reserved mode -> low bw", pll_mode, 2'b00);
        reg_mode_sw_en = 1'b0;
        pll_locked = 1'b1;
        ticks(1);
        chk("R6 back to strap", pll_mode, 2'b11);

        // R8: frequency field
        reg_freq_sw = 2'b10;
        ticks(1);
        chk("R8 ignored when disabled", freq_sel, 0);
        reg_freq_sw_en = 1'b1;
        ticks(1);
        chk("R8 125 MHz code", freq_sel, 2'b10);
        reg_freq_sw = 2'b11;
        ticks(2);
        chk("R8 reserved keeps previous", freq_sel, 2'b10);
        reg_freq_sw = 2'b01;
        ticks(1);
        chk("R8 50 MHz code", freq_sel, 2'b01);
        freq_exp = 2'b01;

        // R3/R4: power-down and wake-up keep the strap
        pwrgd_pin = 1'b0; mode_pin = 2'b00;
        ticks(4);
        pwr_exp = 1'b0;
        chk("R3 power-down parks", out_run, 0);
        chk("R3 power-down pll_pd", pll_pd, 1);
        pwrgd_pin = 1'b1;
        ticks(5);
        pwr_exp = 1'b1;
        chk("R4 strap kept after wake", mode_rdbk, 2'b11);
        check_all("after wake");

        // random mix
        for (int it = 0; it < 400; it++) begin
            reg_oe_en      = N_OUT'($urandom);
            oe_n_pin       = N_OUT'($urandom);
            pll_locked     = 1'($urandom);
            reg_mode_sw_en = 1'($urandom);
            reg_mode_sw    = 2'($urandom);
            reg_freq_sw_en = 1'($urandom);
            reg_freq_sw    = 2'($urandom);
            mode_pin       = 2'($urandom);
            if ($urandom_range(0, 7) == 0) pwrgd_pin = ~pwrgd_pin;
            upd_freq();
            ticks(6);
            pwr_exp = pwrgd_pin;
            check_all("random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule